// File: doc/BRIEF.md
# Cartridge Banking and Freeze Controller

This block is the control logic of a memory expansion cartridge on an 8-bit home computer bus. One control register, decoded at offset 0 of the first I/O window, chooses a 3-bit upper ROM bank address and picks between cartridge ROM and cartridge RAM. It also drives the two active-low cartridge mapping lines, GAME and EXROM, which set how the host maps the cartridge into its address space. A write that sets the kill bit removes the cartridge from the map until the next reset.

A freeze button input is synchronised and debounced. On a clean press the block enters freeze mode and issues a fixed-length NMI request. It selects bank 0 and maps it into the top address window, so the host's NMI vector is fetched from the cartridge. While frozen, the block holds GAME and EXROM in the freeze map and ignores the mapping bits of register writes. Bank and RAM selection still follow those writes. Freeze ends only when software writes the release bit. RAM is then reachable only through the I/O window.

The controller is one state machine with three states: ST_NORMAL, ST_FROZEN and ST_KILLED. Its transitions are:
- ST_NORMAL to ST_FROZEN on a debounced button rise.
- ST_NORMAL or ST_FROZEN to ST_KILLED on a control write with bit 2 set.
- ST_FROZEN to ST_NORMAL on a control write with bit 6 set and bit 2 clear.
- ST_KILLED left only by reset.

If a button rise and a control write arrive in the same cycle in ST_NORMAL, freeze entry wins and the write is discarded.

Top module: `cart_freeze_ctrl`

## Requirements
- R1: After reset the state is ST_NORMAL and every register field is 0. The outputs are then `bank_addr`=0, `ram_sel`=0, `game_n`=1, `exrom_n`=0, `nmi_req`=0 and `hi_map`=0.
- R2: In ST_NORMAL, a write of byte d to offset 0 (with d bit 2 = 0) sets `bank_addr` to {d[7],d[4],d[3]} (MSB first) and `ram_sel` to d[5]. The outputs show this at the clock edge that takes the write.
- R3: In ST_NORMAL, `game_n` equals the inverse of the last written bit 0, and `exrom_n` equals the last written bit 1.
- R4: A read at offset 0 outside ST_KILLED raises `bus_rd_oe` and returns {bank[2],1,1,bank[1],bank[0],pressed,0,0}. Here pressed is the debounced button level. Reads at any other offset leave `bus_rd_oe` low and `bus_rdata` at 0.
- R5: Writes to offset 1 (secondary register) and to every offset other than 0 change no output.
- R6: In ST_NORMAL, a debounced rising edge of `freeze_btn` enters ST_FROZEN. The outputs become `bank_addr`=0, `ram_sel`=0, `game_n`=0, `exrom_n`=1 and `hi_map`=1.
- R7: Each freeze entry raises `nmi_req` for exactly NMI_CYC consecutive cycles, starting in the cycle `hi_map` rises.
- R8: In ST_FROZEN, offset-0 writes update `bank_addr` and `ram_sel` as in R2. `game_n`=0, `exrom_n`=1 and `hi_map`=1 hold unless bit 6 is set.
- R9: In ST_FROZEN, an offset-0 write with bit 6 = 1 returns to ST_NORMAL in that write's clock edge, with `game_n`/`exrom_n` taken from its bits 0/1. In ST_NORMAL, bit 6 has no effect.
- R10: Button pulses shorter than DEB_CYC cycles are ignored. A press while in ST_FROZEN raises no further NMI.
- R11: An offset-0 write with bit 2 = 1 enters ST_KILLED. There `game_n`=`exrom_n`=1, `bank_addr`=0, `ram_sel`=0 and `bus_rd_oe`=0, and writes and button presses are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access to the first I/O window this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IO_AW | Offset within the I/O window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not driving |
| bus_rd_oe | output | 1 | Block drives read data |
| freeze_btn | input | 1 | Raw freeze button, high = pressed |
| nmi_req | output | 1 | NMI request pulse |
| game_n | output | 1 | GAME mapping line, active low |
| exrom_n | output | 1 | EXROM mapping line, active low |
| bank_addr | output | 3 | ROM bank address {A15,A14,A13} |
| ram_sel | output | 1 | 1 = cartridge RAM, 0 = ROM |
| hi_map | output | 1 | Selected bank appears at the top window (freeze) |

## Verification
The bench builds the block with DEB_CYC=4 and NMI_CYC=3. The short debounce lets a few dozen full press and release cycles fit among hundreds of random register accesses. Glitches of DEB_CYC-2 cycles then fall just under the filter threshold. The short NMI length makes the exact pulse width cheap to count on every freeze entry. The defaults (IO_AW=8, offset 0) keep the secondary offset and the rest of the 256-byte window reachable, so ignored writes are exercised at every other offset.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_FROZEN = 2'd1,
        ST_KILLED = 2'd2
    } cfc_state_e;

    localparam int DATA_W = 8;
    localparam int BANK_W = 3;

    // Bit positions in the control byte; the software side decodes these.
    localparam int B_A15   = 7;
    localparam int B_REL   = 6;
    localparam int B_RAM   = 5;
    localparam int B_A14   = 4;
    localparam int B_A13   = 3;
    localparam int B_KILL  = 2;
    localparam int B_EXROM = 1;
    localparam int B_GAME  = 0;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              ram;
        logic              game;
        logic              exrom;
    } cfc_ctl_t;

endpackage

// File: rtl/cfc_debounce.sv
module cfc_debounce #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic rise
);
    localparam int CW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

    logic          s1_q, s2_q, level_q, rise_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            s1_q   <= raw;
            s2_q   <= s1_q;
            rise_q <= 1'b0;
            if (s2_q == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                level_q <= s2_q;
                rise_q  <= s2_q;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level = level_q;
    assign rise  = rise_q;
endmodule

// File: rtl/cfc_nmi_pulse.sv
module cfc_nmi_pulse #(
    parameter int NMI_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic nmi
);
    localparam int CW = $clog2(NMI_CYC + 1);
    localparam logic [CW-1:0] LEN = CW'(NMI_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (trig)          cnt_q <= LEN;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign nmi = (cnt_q != '0);
endmodule

// File: rtl/cfc_bus_decode.sv
module cfc_bus_decode #(
    parameter int IO_AW   = 8,
    parameter int CTL_OFF = 0
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IO_AW-1:0] bus_addr,
    input  logic             active,
    output logic             wr_ctl,
    output logic             rd_ctl
);
    localparam logic [IO_AW-1:0] OFF = IO_AW'(CTL_OFF);

    logic hit;

    // Every other offset (the secondary register included) is accepted and dropped.
    always_comb begin
        hit    = bus_sel && active && (bus_addr == OFF);
        wr_ctl = hit && bus_wr;
        rd_ctl = hit && !bus_wr;
    end
endmodule

// File: rtl/cart_freeze_ctrl.sv
module cart_freeze_ctrl
    import cfc_pkg::*;
#(
    parameter int IO_AW   = 8,
    parameter int CTL_OFF = 0,
    parameter int DEB_CYC = 16,
    parameter int NMI_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IO_AW-1:0]  bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rd_oe,
    input  logic              freeze_btn,
    output logic              nmi_req,
    output logic              game_n,
    output logic              exrom_n,
    output logic [2:0]        bank_addr,
    output logic              ram_sel,
    output logic              hi_map
);
    cfc_state_e state_q, state_d;
    cfc_ctl_t   ctl_q, ctl_d;
    logic       wr_ctl, rd_ctl, btn_level, btn_rise, enter_frz, active;
    logic       killed_w;

    assign active   = (state_q != ST_KILLED);
    assign killed_w = (state_q == ST_KILLED);

    cfc_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk(clk), .rst_n(rst_n), .raw(freeze_btn),
        .level(btn_level), .rise(btn_rise)
    );

    cfc_bus_decode #(.IO_AW(IO_AW), .CTL_OFF(CTL_OFF)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .active(active), .wr_ctl(wr_ctl), .rd_ctl(rd_ctl)
    );

    cfc_nmi_pulse #(.NMI_CYC(NMI_CYC)) u_nmi (
        .clk(clk), .rst_n(rst_n), .trig(enter_frz), .nmi(nmi_req)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        ctl_d     = ctl_q;
        enter_frz = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (btn_rise) begin
                    state_d    = ST_FROZEN;
                    ctl_d.bank = '0;
                    ctl_d.ram  = 1'b0;
                    enter_frz  = 1'b1;
                end else if (wr_ctl) begin
                    if (bus_wdata[B_KILL]) begin
                        state_d = ST_KILLED;
                    end else begin
                        ctl_d.bank  = {bus_wdata[B_A15], bus_wdata[B_A14], bus_wdata[B_A13]};
                        ctl_d.ram   = bus_wdata[B_RAM];
                        ctl_d.game  = bus_wdata[B_GAME];
                        ctl_d.exrom = bus_wdata[B_EXROM];
                    end
                end
            end
            ST_FROZEN: begin
                if (wr_ctl) begin
                    if (bus_wdata[B_KILL]) begin
                        state_d = ST_KILLED;
                    end else begin
                        ctl_d.bank = {bus_wdata[B_A15], bus_wdata[B_A14], bus_wdata[B_A13]};
                        ctl_d.ram  = bus_wdata[B_RAM];
                        if (bus_wdata[B_REL]) begin
                            state_d     = ST_NORMAL;
                            ctl_d.game  = bus_wdata[B_GAME];
                            ctl_d.exrom = bus_wdata[B_EXROM];
                        end
                    end
                end
            end
            ST_KILLED: begin
                state_d = ST_KILLED;
            end
            default: begin
                state_d = ST_KILLED;
            end
        endcase
    end

    // Outputs
    always_comb begin
        bank_addr = ctl_q.bank;
        ram_sel   = ctl_q.ram;
        hi_map    = 1'b0;
        game_n    = ~ctl_q.game;
        exrom_n   = ctl_q.exrom;
        unique case (state_q)
            ST_NORMAL: ;
            ST_FROZEN: begin
                hi_map  = 1'b1;
                game_n  = 1'b0;
                exrom_n = 1'b1;
            end
            ST_KILLED: begin
                bank_addr = '0;
                ram_sel   = 1'b0;
                game_n    = 1'b1;
                exrom_n   = 1'b1;
            end
            default: begin
                bank_addr = '0;
                ram_sel   = 1'b0;
                game_n    = 1'b1;
                exrom_n   = 1'b1;
            end
        endcase
        bus_rd_oe = rd_ctl;
        bus_rdata = rd_ctl ? {ctl_q.bank[2], 1'b1, 1'b1, ctl_q.bank[1], ctl_q.bank[0],
                              btn_level, 1'b0, 1'b0}
                           : 8'h00;
    end
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
    parameter int NMI_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       game_n,
    input logic       exrom_n,
    input logic       nmi_req,
    input logic       hi_map,
    input logic       bus_rd_oe,
    input logic [7:0] bus_rdata,
    input logic       killed
);
    localparam int CW = $clog2(NMI_CYC + 2);
    logic [CW-1:0] nmi_run;

    always_ff @(posedge clk) begin
        if (!rst_n)       nmi_run <= '0;
        else if (nmi_req) nmi_run <= nmi_run + 1'b1;
        else              nmi_run <= '0;
    end

    assert_freeze_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_map |-> (!game_n && exrom_n));

    assert_nmi_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $rose(hi_map));

    assert_nmi_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_run <= CW'(NMI_CYC));

    assert_frozen_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_map && $past(hi_map)) |-> $stable({game_n, exrom_n}));

    assert_read_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_oe |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[1:0] == 2'b00));

    assert_kill_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        killed |=> (killed && game_n && exrom_n && !bus_rd_oe && !hi_map));
endmodule

bind cart_freeze_ctrl cfc_checker #(.NMI_CYC(NMI_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .game_n(game_n), .exrom_n(exrom_n),
    .nmi_req(nmi_req), .hi_map(hi_map), .bus_rd_oe(bus_rd_oe),
    .bus_rdata(bus_rdata), .killed(killed_w)
);

// File: tb/sim_cart_freeze_ctrl.sv
module sim_cart_freeze_ctrl;
    localparam int DEB = 4;
    localparam int NMI = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_rd_oe, freeze_btn = 1'b0, nmi_req, game_n, exrom_n, ram_sel, hi_map;
    logic [2:0] bank_addr;

    always #5 clk = ~clk;

    cart_freeze_ctrl #(.IO_AW(8), .CTL_OFF(0), .DEB_CYC(DEB), .NMI_CYC(NMI)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd_oe(bus_rd_oe), .freeze_btn(freeze_btn), .nmi_req(nmi_req),
        .game_n(game_n), .exrom_n(exrom_n), .bank_addr(bank_addr),
        .ram_sel(ram_sel), .hi_map(hi_map)
    );

    int n_chk = 0, n_bad = 0, nmi_hi = 0, nmi_rises = 0;
    logic nmi_prev = 1'b0;
    // model: 0 normal, 1 frozen, 2 killed
    int m_st = 0;
    logic [2:0] m_bank = 0;
    logic m_ram = 0, m_game = 0, m_exrom = 0;

    always @(negedge clk) begin
        if (nmi_req) nmi_hi++;
        if (nmi_req && !nmi_prev) nmi_rises++;
        nmi_prev = nmi_req;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_pins();
        case (m_st)
            0: return {~m_game, m_exrom, m_bank, m_ram, 1'b0};
            1: return {1'b0, 1'b1, m_bank, m_ram, 1'b1};
            default: return 7'b1100000;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic pressed);
        return {m_bank[2], 2'b11, m_bank[1], m_bank[0], pressed, 2'b00};
    endfunction

    function automatic logic [6:0] pins();
        return {game_n, exrom_n, bank_addr, ram_sel, hi_map};
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
        if (a != 8'h00 || m_st == 2) return;
        if (d[2]) begin m_st = 2; return; end
        m_bank = {d[7], d[4], d[3]};
        m_ram  = d[5];
        if (m_st == 0 || d[6]) begin
            m_st = 0; m_game = d[0]; m_exrom = d[1];
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        model_wr(a, d);
        chk(tag, pins(), exp_pins());
    endtask

    task automatic bus_read(input logic [7:0] a, input logic pressed, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        if (a == 8'h00 && m_st != 2) begin
            chk({tag, " oe"}, bus_rd_oe, 1);
            chk({tag, " data"}, bus_rdata, exp_rd(pressed));
        end else begin
            chk({tag, " oe"}, bus_rd_oe, 0);
            chk({tag, " data"}, bus_rdata, 0);
        end
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic press(input int hold, input bool_read);
        int h0, r0;
        bit was_norm;
        h0 = nmi_hi; r0 = nmi_rises;
        was_norm = (m_st == 0) && (hold >= DEB + 2);
        @(negedge clk);
        freeze_btn = 1;
        repeat (hold) @(negedge clk);
        if (bool_read) bus_read(8'h00, 1'b1, "R4 pressed");
        freeze_btn = 0;
        repeat (DEB + 8) @(negedge clk);
        if (was_norm) begin
            m_st = 1; m_bank = 0; m_ram = 0;
            chk("R6 freeze map", pins(), exp_pins());
            chk("R7 nmi rises", nmi_rises - r0, 1);
            chk("R7 nmi width", nmi_hi - h0, NMI);
        end else begin
            chk("R10 no effect", pins(), exp_pins());
            chk("R10 no nmi", nmi_rises - r0, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_st = 0; m_bank = 0; m_ram = 0; m_game = 0; m_exrom = 0;
        @(negedge clk);
        chk("R1 reset pins", pins(), 7'b1000000);
        chk("R1 reset nmi", nmi_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        bus_read(8'h00, 1'b0, "R1 R4 reset read");
        // directed
        bus_write(8'h00, 8'hBB, "R2 R3 write");
        bus_write(8'h00, 8'h43, "R9 bit6 in normal");
        bus_write(8'h01, 8'hFF, "R5 secondary");
        bus_write(8'h37, 8'h00, "R5 other offset");
        bus_read(8'h01, 1'b0, "R4 other read");
        press(DEB - 2, 0);               // R10 glitch
        press(DEB + 6, 1);               // R6 R7 with pressed read
        press(DEB + 6, 0);               // R10 press while frozen
        bus_write(8'h00, 8'hB8, "R8 frozen bank");
        bus_read(8'h00, 1'b0, "R4 frozen read");
        bus_write(8'h00, 8'h41, "R9 release");
        // random
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom % 10;
            d  = 8'($urandom) & 8'hFB;
            case (op)
                0, 1, 2, 3: bus_write(8'h00, d, m_st == 1 ? "R8 R9 rand" : "R2 R3 rand");
                4: bus_write(8'h01, 8'($urandom), "R5 rand sec");
                5: bus_write(8'(2 + $urandom % 254), 8'($urandom), "R5 rand off");
                6, 7: bus_read(8'($urandom % 3), 1'b0, "R4 rand read");
                8: press(DEB + 4 + $urandom % 4, 0);
                default: press(1 + $urandom % (DEB - 2), 0);
            endcase
        end
        // kill
        bus_write(8'h00, 8'h04, "R11 kill");
        bus_read(8'h00, 1'b0, "R11 read");
        bus_write(8'h00, 8'hC3, "R11 write ignored");
        press(DEB + 6, 0);
        chk("R11 still killed", pins(), 7'b1100000);
        do_reset();
        bus_write(8'h00, 8'h21, "R2 after reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule